// File: doc/BRIEF.md
# Split-Section Test Counter

This block is a 16-bit binary up-counter made of two 8-bit sections, with test control points that let a tester run the sections apart or as one. In functional mode the low section counts every enabled cycle, and its wrap from all-ones to zero advances the high section. The pair then behaves as one 16-bit counter.

In test mode two control points reshape the counter. A carry-inhibit input cuts the chain between the sections and feeds the high section from a tester data input. A clock-inhibit input takes the functional count enable away from both sections and hands stepping to a tester strobe. The low section is also brought out on an observation port. With the chain cut and tester data held high, both sections sweep all 256 states at the same time. A full test then takes 256 steps instead of 65536.

All clocking is synchronous to one clock. The tester clock is a one-cycle step strobe, not a second clock domain.

Top module: `part_counter`

## Requirements
- R1: While `rst` is high, `count` is zero at the next clock edge.
- R2: In functional mode (`test_mode`=0), `count` rises by one on each edge where `cnt_en`=1, and holds when `cnt_en`=0.
- R3: In functional mode the high section changes only on the edge where the low section goes from 0xFF to 0x00. `count` wraps from 0xFFFF to 0x0000.
- R4: In functional mode, `carry_blk`, `tst_data`, `clk_blk` and `tst_tick` have no effect on `count`.
- R5: `clr`=1 sets both sections to zero on the next edge in either mode, and it takes priority over counting.
- R6: In test mode with `carry_blk`=1, the high section advances on a step exactly when `tst_data`=1, whatever the low section holds. The tester data acts on the same edge where a carry would have acted.
- R7: In test mode with `carry_blk`=0, the low-section wrap carries into the high section as in functional mode.
- R8: In test mode with `clk_blk`=1, a step happens only on cycles with `tst_tick`=1, and `cnt_en` is ignored. With `clk_blk`=0 the step is `cnt_en`.
- R9: `lo_obs` always equals bits 7:0 of `count`.
- R10: In test mode with `carry_blk`=1 and `tst_data`=1, 256 steps from zero move both sections through every value together (`count` = k*0x0101 after k steps) and return them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both sections, either mode |
| cnt_en | input | 1 | Functional count enable |
| test_mode | input | 1 | 1 selects test mode |
| carry_blk | input | 1 | Carry-inhibit control point (test mode) |
| tst_data | input | 1 | Tester data for the high section when the carry is inhibited |
| clk_blk | input | 1 | Clock-inhibit control point (test mode) |
| tst_tick | input | 1 | Tester step strobe used while the clock is inhibited |
| count | output | 16 | Counter value, high section in bits 15:8 |
| lo_obs | output | 8 | Observation point on the low section |

## Verification
Assertions check on every cycle that each section holds or steps by exactly one, that a clear zeroes the counter on the next edge, and that the high section moves in functional mode only on a low wrap. They also check that a cut chain with tester data low freezes the high section, and that an inhibited clock without a tester strobe freezes the whole count. Whether the full 16-bit sequence is visited in order, whether the control points stay inert in functional mode, and whether the parallel 256-step sweep ends back at zero can only be shown by the bench's sweeps. The bench compares against an arithmetic count on every cycle.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic {
        STEP_FUNC   = 1'b0,
        STEP_TESTER = 1'b1
    } step_src_e;

    typedef enum logic {
        LINK_CHAIN  = 1'b0,
        LINK_TESTER = 1'b1
    } link_src_e;

    typedef struct packed {
        logic test_mode;
        logic carry_blk;
        logic clk_blk;
        logic tst_data;
        logic tst_tick;
        logic cnt_en;
        logic clr;
    } pcnt_ctl_t;

    typedef struct packed {
        logic      step;
        logic      clr;
        logic      tdata;
        link_src_e link;
    } pcnt_drive_t;

    function automatic step_src_e pick_step(input pcnt_ctl_t c);
        return (c.test_mode && c.clk_blk) ? STEP_TESTER : STEP_FUNC;
    endfunction

    function automatic link_src_e pick_link(input pcnt_ctl_t c);
        return (c.test_mode && c.carry_blk) ? LINK_TESTER : LINK_CHAIN;
    endfunction

endpackage

// File: rtl/pcnt_mode_ctl.sv
module pcnt_mode_ctl
    import pcnt_pkg::*;
(
    input  pcnt_ctl_t   ctl,
    output pcnt_drive_t drv
);
    step_src_e ssrc;

    always_comb begin
        ssrc      = pick_step(ctl);
        drv.clr   = ctl.clr;
        drv.tdata = ctl.tst_data;
        drv.link  = pick_link(ctl);
        case (ssrc)
            STEP_TESTER: drv.step = ctl.tst_tick;
            default:     drv.step = ctl.cnt_en;
        endcase
    end
endmodule

// File: rtl/pcnt_link.sv
module pcnt_link
    import pcnt_pkg::*;
(
    input  link_src_e link,
    input  logic      step,
    input  logic      carry_in,
    input  logic      tdata,
    output logic      inc
);
    always_comb begin
        case (link)
            LINK_TESTER: inc = step & tdata;
            default:     inc = carry_in;
        endcase
    end
endmodule

// File: rtl/pcnt_section.sv
module pcnt_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         cy
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            val <= '0;
        else if (inc)
            val <= val + 1'b1;
    end

    assign cy = inc && (val == TOP);

    // R5: clear forces the section to zero
    a_r5_sec_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (val == '0));

    // R2: no increment request, no change
    a_r2_sec_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(val));

    // R2: an increment request advances by exactly one
    a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> (val == W'($past(val) + 1'b1)));
endmodule

// File: rtl/part_counter.sv
module part_counter
    import pcnt_pkg::*;
#(
    parameter  int SEC_W = 8,
    parameter  int SEC_N = 2,
    localparam int CNT_W = SEC_W * SEC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             test_mode,
    input  logic             carry_blk,
    input  logic             tst_data,
    input  logic             clk_blk,
    input  logic             tst_tick,
    output logic [CNT_W-1:0] count,
    output logic [SEC_W-1:0] lo_obs
);
    localparam logic [SEC_W-1:0] SEC_TOP = '1;

    pcnt_ctl_t   ctl;
    pcnt_drive_t drv;

    logic [SEC_W-1:0] sec_val [SEC_N];
    logic [SEC_N-1:0] sec_inc;
    logic [SEC_N-1:0] sec_cy;

    always_comb begin
        ctl.test_mode = test_mode;
        ctl.carry_blk = carry_blk;
        ctl.clk_blk   = clk_blk;
        ctl.tst_data  = tst_data;
        ctl.tst_tick  = tst_tick;
        ctl.cnt_en    = cnt_en;
        ctl.clr       = clr;
    end

    pcnt_mode_ctl u_mode (
        .ctl (ctl),
        .drv (drv)
    );

    genvar gi;
    generate
        for (gi = 0; gi < SEC_N; gi++) begin : g_sec
            if (gi == 0) begin : g_first
                assign sec_inc[gi] = drv.step;
            end else begin : g_linked
                pcnt_link u_link (
                    .link     (drv.link),
                    .step     (drv.step),
                    .carry_in (sec_cy[gi-1]),
                    .tdata    (drv.tdata),
                    .inc      (sec_inc[gi])
                );
            end

            pcnt_section #(.W(SEC_W)) u_sec (
                .clk (clk),
                .rst (rst),
                .clr (drv.clr),
                .inc (sec_inc[gi]),
                .val (sec_val[gi]),
                .cy  (sec_cy[gi])
            );

            assign count[gi*SEC_W +: SEC_W] = sec_val[gi];
        end
    endgenerate

    assign lo_obs = sec_val[0];

    // R1: reset clears the whole count
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R3: functional-mode low wrap advances the high section by one
    a_r3_wrap_carry: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && !clr && cnt_en && lo_obs == SEC_TOP)
        |=> (lo_obs == '0) && (sec_val[1] == SEC_W'($past(sec_val[1]) + 1'b1)));

    // R3: functional-mode high section frozen without a low wrap
    a_r3_no_stray_hi: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && !clr && !(cnt_en && lo_obs == SEC_TOP))
        |=> $stable(sec_val[1]));

    // R6: cut chain with tester data low freezes the high section
    a_r6_cut_hold: assert property (@(posedge clk) disable iff (rst)
        (test_mode && carry_blk && !tst_data && !clr) |=> $stable(sec_val[1]));

    // R8: inhibited clock without a tester strobe freezes everything
    a_r8_tick_only: assert property (@(posedge clk) disable iff (rst)
        (test_mode && clk_blk && !tst_tick && !clr) |=> $stable(count));
endmodule

// File: tb/sim_part_counter.sv
module sim_part_counter;
    logic        clk = 1'b0;
    logic        rst, clr, cnt_en, test_mode, carry_blk, tst_data, clk_blk, tst_tick;
    logic [15:0] count;
    logic [7:0]  lo_obs;

    int checks   = 0;
    int failures = 0;
    int exp_lo   = 0;
    int exp_hi   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    part_counter u0 (
        .clk(clk), .rst(rst), .clr(clr), .cnt_en(cnt_en), .test_mode(test_mode),
        .carry_blk(carry_blk), .tst_data(tst_data), .clk_blk(clk_blk),
        .tst_tick(tst_tick), .count(count), .lo_obs(lo_obs)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive, let the edge happen, advance the arithmetic model, compare.
    task automatic cyc(input bit tm, input bit cb, input bit kb, input bit td,
                       input bit tk, input bit en, input bit cl, input string tag);
        bit step;
        bit hi_up;
        @(negedge clk);
        test_mode = tm; carry_blk = cb; clk_blk = kb; tst_data = td;
        tst_tick = tk; cnt_en = en; clr = cl;
        @(posedge clk);
        #1;
        step  = (tm && kb) ? tk : en;
        hi_up = (tm && cb) ? (step && td) : (step && exp_lo == 255);
        if (cl) begin
            exp_lo = 0; exp_hi = 0;
        end else begin
            if (hi_up) exp_hi = (exp_hi + 1) % 256;
            if (step)  exp_lo = (exp_lo + 1) % 256;
        end
        check(tag, count, exp_hi * 256 + exp_lo);
        check("R9 lo_obs", lo_obs, count[7:0]);
    endtask

    initial begin
        rst = 1'b1; clr = 0; cnt_en = 0; test_mode = 0; carry_blk = 0;
        tst_data = 0; clk_blk = 0; tst_tick = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", count, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: full functional sweep, compared with k mod 65536
        for (int k = 1; k <= 65536; k++) begin
            cyc(0, 0, 0, 0, 0, 1, 0, "R3 sweep");
            if (k == 65536) check("R3 full wrap", count, 0);
        end
        for (int k = 0; k < 300; k++) cyc(0, 0, 0, 0, 0, 1, 0, "R2 count");
        for (int k = 0; k < 5; k++)   cyc(0, 0, 0, 0, 0, 0, 0, "R2 hold");

        // R4: control points toggling in functional mode
        for (int k = 0; k < 600; k++)
            cyc(0, 1, 1, k[0], k[1], 1, 0, "R4 inert");
        for (int k = 0; k < 6; k++)
            cyc(0, 1, 1, 1, 1, 0, 0, "R4 inert hold");

        // R5: clear in functional mode, then with a step pending
        cyc(0, 0, 0, 0, 0, 1, 1, "R5 clear func");
        check("R5 zero", count, 0);
        for (int k = 0; k < 40; k++) cyc(1, 1, 0, 1, 0, 1, 0, "R6 pre");
        cyc(1, 1, 1, 1, 1, 1, 1, "R5 clear test");
        check("R5 zero test", count, 0);

        // R10: parallel sweep of both sections
        for (int k = 1; k <= 256; k++) begin
            cyc(1, 1, 0, 1, 0, 1, 0, "R10 parallel");
            check("R10 lockstep", count, (k % 256) * 257);
        end

        // R6: cut chain, tester data low: high frozen while low wraps
        cyc(1, 1, 0, 1, 0, 1, 0, "R6 seed");
        for (int k = 0; k < 300; k++) cyc(1, 1, 0, 0, 0, 1, 0, "R6 cut");
        check("R6 hi frozen", count[15:8], 1);
        // R6: tester data pulses act without a low wrap
        for (int k = 0; k < 20; k++) cyc(1, 1, 0, k[0], 0, 1, 0, "R6 tdata");

        // R7: test mode, chain closed: carry propagates
        cyc(1, 0, 0, 0, 0, 0, 1, "R7 clear");
        for (int k = 0; k < 520; k++) cyc(1, 0, 0, 0, 0, 1, 0, "R7 chain");
        check("R7 two carries", count, 520);

        // R8: clock inhibited, enable ignored, strobe steps
        for (int k = 0; k < 10; k++) cyc(1, 0, 1, 0, 0, 1, 0, "R8 no tick");
        for (int k = 0; k < 30; k++) cyc(1, 0, 1, 0, k[0], 0, 0, "R8 tick");
        check("R8 tick count", count, 535);
        for (int k = 0; k < 10; k++) cyc(1, 1, 1, 1, 1, 0, 0, "R8 R6 both");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule